// File: doc/BRIEF.md
# Two-Channel Interval Timer with Capture and PWM

This peripheral holds two independent 32-bit counting channels that share one small register space. Every channel owns a control/status word, a load value and a live counter. In generate mode a channel counts from its load value toward a terminal count. Each time it gets there it raises its interrupt flag and pulses an event line for one cycle, and it either reloads or keeps stepping. In capture mode the counter runs freely, and a selected edge on the channel's capture pin copies the count into the load register.

A common tick-enable input gates all counting, so a slower count rate comes from pulsing that input. When both channels are placed in PWM mode, channel 0 sets the period and channel 1 sets the high time of one pulse-width-modulated output. Software reads and writes the registers through a single-cycle bus: a write strobe, a 3-bit word address and write data. Read data is combinational from the address.

Top module: `dual_timer`

## Requirements
- R1: After reset every register reads zero, and evtOut, irq and pwmOut are low.
- R2: Address bit 2 selects the channel. Address bits 1:0 select the control/status word (0), the load register (1) or the counter (2). The load register reads back what was written. Writes to the counter or to word 3 change nothing, and word 3 reads zero. Control bits: 0 capture mode, 1 count down, 2 auto-reload, 3 load, 4 interrupt enable, 5 run, 6 PWM enable, 7 capture on falling edge, 8 interrupt flag.
- R3: In generate mode, a tick with the counter at terminal count sets the flag and drives evtOut high for exactly the following cycle. The counter then reloads from the load register when auto-reload is set, and otherwise steps past the terminal value and wraps.
- R4: The counter moves only on cycles where run and tickEn are both high. It steps by +1 toward a terminal count of all-ones, or by -1 toward zero when the down bit is set.
- R5: While the load bit is set, the counter takes the load register value every cycle, does not count and produces no event.
- R6: In capture mode with run set, the selected edge of the channel's capIn bit writes the pre-edge counter value into the load register and sets the flag. The rising edge is selected when bit 7 is 0 and the falling edge when bit 7 is 1. The other edge has no effect.
- R7: Writing a control word with bit 8 set clears the flag. A write with bit 8 clear leaves the flag as it was. A flag-setting condition in the same cycle wins over the clear.
- R8: With both channels in generate mode and PWM enabled, each channel 0 expiry starts a period: pwmOut goes high and channel 1 is reloaded. pwmOut falls when channel 1 expires, so for down-counting loads P and H with H < P it is high for H+1 of every P+1 ticks. pwmOut is low when PWM is not active.
- R9: irq of a channel is high exactly when its flag and its interrupt enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count enable shared by both channels |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Word address: bit 2 channel, bits 1:0 register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr |
| capIn | input | 2 | Capture event inputs, one per channel |
| evtOut | output | 2 | One-cycle expiry pulses, one per channel |
| irq | output | 2 | Interrupt requests, one per channel |
| pwmOut | output | 1 | Pulse-width-modulated output |

## Verification
Some rules are checked by the assertions on every cycle: an event never appears without its flag, the load bit forces the counter to the load value, a capture-mode counter steps by exactly one per tick, reload after an expiry, flag set after a selected capture edge, irq gating by the enable, and pwmOut going low once PWM is inactive. Other behaviour needs whole sequences, and only the bench scenarios can show it. That covers the length of a generate period in each direction under irregular tick patterns, wrap when auto-reload is off, and the edge selection that must ignore the opposite edge. It also covers the write-one-to-clear flag handling and the high and low widths of the PWM waveform over several periods.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int NCH = 2;
  localparam int FLAG_BIT = 8;

  // Control word, bit 0 is capMode
  typedef struct packed {
    logic capFall;
    logic pwmEn;
    logic run;
    logic intEn;
    logic loadBit;
    logic autoReload;
    logic down;
    logic capMode;
  } ctrlBits_t;

  localparam int CTRL_W = $bits(ctrlBits_t);

  // Strobes from the control block to one channel datapath
  typedef struct packed {
    logic wrCtrl;
    logic wrLoad;
    logic clrFlag;
    logic forceReload;
    logic noAuto;
  } chStrobe_t;
endpackage

// File: rtl/dtmr_chan.sv
module dtmr_chan
  import dtmr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  logic          capIn,
  input  chStrobe_t     strobe,
  input  logic [DW-1:0] wrData,
  output ctrlBits_t     ctrlQ,
  output logic          flagQ,
  output logic [DW-1:0] loadQ,
  output logic [DW-1:0] countQ,
  output logic          expire,
  output logic          evtOut
);
  logic          capPrev;
  logic          capEdge;
  logic          step;
  logic [DW-1:0] termVal;

  assign termVal = ctrlQ.down ? '0 : '1;
  assign step    = ctrlQ.run && tickEn && !ctrlQ.loadBit;
  assign expire  = step && !ctrlQ.capMode && (countQ == termVal);
  assign capEdge = ctrlQ.run && ctrlQ.capMode && !ctrlQ.loadBit &&
                   (ctrlQ.capFall ? (capPrev && !capIn) : (capIn && !capPrev));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      flagQ   <= 1'b0;
      loadQ   <= '0;
      countQ  <= '0;
      capPrev <= 1'b0;
      evtOut  <= 1'b0;
    end else begin
      capPrev <= capIn;
      evtOut  <= expire;

      if (strobe.wrCtrl) ctrlQ <= ctrlBits_t'(wrData[CTRL_W-1:0]);

      if (expire || capEdge)   flagQ <= 1'b1;
      else if (strobe.clrFlag) flagQ <= 1'b0;

      if (capEdge)            loadQ <= countQ;
      else if (strobe.wrLoad) loadQ <= wrData;

      if (ctrlQ.loadBit)                                        countQ <= loadQ;
      else if (strobe.forceReload)                              countQ <= loadQ;
      else if (expire && ctrlQ.autoReload && !strobe.noAuto)    countQ <= loadQ;
      else if (step)  countQ <= ctrlQ.down ? countQ - DW'(1) : countQ + DW'(1);
    end
  end
endmodule

// File: rtl/dtmr_ctrl.sv
module dtmr_ctrl
  import dtmr_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  input  logic          flagWr,
  input  ctrlBits_t     chCtrl  [NCH],
  input  logic          chFlag  [NCH],
  input  logic [DW-1:0] chLoad  [NCH],
  input  logic [DW-1:0] chCount [NCH],
  input  logic          chExpire[NCH],
  output chStrobe_t     strobe  [NCH],
  output logic [DW-1:0] rdData,
  output logic          pwmOut
);
  localparam int SELW = AW - 1;

  logic [SELW-1:0] regSel;
  logic            chSel;
  logic            pwmActive;

  assign regSel    = addr[SELW-1:0];
  assign chSel     = addr[AW-1];
  assign pwmActive = chCtrl[0].pwmEn && chCtrl[1].pwmEn &&
                     !chCtrl[0].capMode && !chCtrl[1].capMode;

  always_comb begin
    for (int ch = 0; ch < NCH; ch++) begin
      strobe[ch].wrCtrl      = wrEn && (int'(chSel) == ch) && (regSel == SELW'(0));
      strobe[ch].wrLoad      = wrEn && (int'(chSel) == ch) && (regSel == SELW'(1));
      strobe[ch].clrFlag     = strobe[ch].wrCtrl && flagWr;
      strobe[ch].forceReload = (ch == NCH - 1) && pwmActive && chExpire[0];
      strobe[ch].noAuto      = (ch == NCH - 1) && pwmActive;
    end
  end

  always_comb begin
    rdData = '0;
    case (regSel)
      SELW'(0): rdData[FLAG_BIT:0] = {chFlag[chSel], chCtrl[chSel]};
      SELW'(1): rdData = chLoad[chSel];
      SELW'(2): rdData = chCount[chSel];
      default:  rdData = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)            pwmOut <= 1'b0;
    else if (!pwmActive)  pwmOut <= 1'b0;
    else if (chExpire[0]) pwmOut <= 1'b1;
    else if (chExpire[1]) pwmOut <= 1'b0;
  end
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dtmr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  logic          wrEn,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  input  logic [1:0]    capIn,
  output logic [1:0]    evtOut,
  output logic [1:0]    irq,
  output logic          pwmOut
);
  localparam int AW = 3;

  ctrlBits_t     chCtrl  [NCH];
  logic          chFlag  [NCH];
  logic [DW-1:0] chLoad  [NCH];
  logic [DW-1:0] chCount [NCH];
  logic          chExpire[NCH];
  chStrobe_t     strobe  [NCH];

  dtmr_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .addr     (addr),
    .flagWr   (wrData[FLAG_BIT]),
    .chCtrl   (chCtrl),
    .chFlag   (chFlag),
    .chLoad   (chLoad),
    .chCount  (chCount),
    .chExpire (chExpire),
    .strobe   (strobe),
    .rdData   (rdData),
    .pwmOut   (pwmOut)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    dtmr_chan #(.DW(DW)) u_chan (
      .clk    (clk),
      .rstN   (rstN),
      .tickEn (tickEn),
      .capIn  (capIn[ch]),
      .strobe (strobe[ch]),
      .wrData (wrData),
      .ctrlQ  (chCtrl[ch]),
      .flagQ  (chFlag[ch]),
      .loadQ  (chLoad[ch]),
      .countQ (chCount[ch]),
      .expire (chExpire[ch]),
      .evtOut (evtOut[ch])
    );
    assign irq[ch] = chFlag[ch] && chCtrl[ch].intEn;
  end
endmodule

// File: rtl/dtmr_chk.sv
module dtmr_chk
  import dtmr_pkg::*;
#(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          tickEn,
  input logic [1:0]    capIn,
  input logic [1:0]    evtOut,
  input logic [1:0]    irq,
  input logic          pwmOut,
  input ctrlBits_t     chCtrl [NCH],
  input logic          chFlag [NCH],
  input logic [DW-1:0] chLoad [NCH],
  input logic [DW-1:0] chCount[NCH]
);
  logic pwmOn;
  assign pwmOn = chCtrl[0].pwmEn && chCtrl[1].pwmEn &&
                 !chCtrl[0].capMode && !chCtrl[1].capMode;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    p_evt_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
      evtOut[i] |-> chFlag[i]);

    p_reload_r3: assert property (@(posedge clk) disable iff (!rstN)
      (evtOut[i] && $past(chCtrl[i].autoReload) && !$past(pwmOn))
        |-> chCount[i] == $past(chLoad[i]));

    p_load_copy_r5: assert property (@(posedge clk) disable iff (!rstN)
      chCtrl[i].loadBit |=> chCount[i] == $past(chLoad[i]));

    p_cap_step_r4: assert property (@(posedge clk) disable iff (!rstN)
      (chCtrl[i].run && chCtrl[i].capMode && !chCtrl[i].loadBit && tickEn)
        |=> chCount[i] == ($past(chCtrl[i].down) ? $past(chCount[i]) - DW'(1)
                                                 : $past(chCount[i]) + DW'(1)));

    p_cap_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
      (chCtrl[i].run && chCtrl[i].capMode && !chCtrl[i].loadBit &&
       (chCtrl[i].capFall ? $fell(capIn[i]) : $rose(capIn[i]))) |=> chFlag[i]);

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
      !chCtrl[i].intEn |-> !irq[i]);
  end

  p_pwm_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !pwmOn |=> !pwmOut);
endmodule

bind dual_timer dtmr_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .tickEn  (tickEn),
  .capIn   (capIn),
  .evtOut  (evtOut),
  .irq     (irq),
  .pwmOut  (pwmOut),
  .chCtrl  (chCtrl),
  .chFlag  (chFlag),
  .chLoad  (chLoad),
  .chCount (chCount)
);

// File: tb/sim_dual_timer.sv
module sim_dual_timer;
  localparam logic [31:0] CAP = 32'h1, DOWN = 32'h2, AUTO = 32'h4, LOADB = 32'h8;
  localparam logic [31:0] INTEN = 32'h10, RUN = 32'h20, PWM = 32'h40, FALL = 32'h80;
  localparam logic [31:0] FLAGW = 32'h100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [1:0]  capIn = '0;
  logic [1:0]  evtOut;
  logic [1:0]  irq;
  logic        pwmOut;

  int nChecks = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  dual_timer u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .capIn(capIn), .evtOut(evtOut),
    .irq(irq), .pwmOut(pwmOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  function automatic longint unsigned periodOf(input logic [31:0] l, input bit dn);
    return dn ? longint'(l) + 1 : 64'h1_0000_0000 - longint'(l);
  endfunction

  function automatic logic [31:0] expCnt(input logic [31:0] l, input bit dn,
                                         input longint unsigned tk);
    longint unsigned ph;
    ph = tk % periodOf(l, dn);
    return dn ? l - 32'(ph) : l + 32'(ph);
  endfunction

  function automatic bit expPwm(input int lp, input int lh, input int t);
    if (t < lp + 1) return 1'b0;
    return ((t - (lp + 1)) % (lp + 1)) < (lh + 1);
  endfunction

  logic [31:0] rd, l, mode, c;
  int ch;
  bit dn, tkE;
  longint unsigned tk;
  int lp, lh;

  initial begin
    #(4 * 150000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      busRead(3'(a), rd);
      check("R1 reg after reset", rd, 32'h0);
    end
    check("R1 outputs after reset", {29'b0, evtOut, pwmOut}, 32'h0);
    check("R1 irq after reset", {30'b0, irq}, 32'h0);

    // R2 register map
    busWrite(3'd1, 32'hA5A5_1234);
    busRead(3'd1, rd);  check("R2 load readback", rd, 32'hA5A5_1234);
    busWrite(3'd2, 32'h0000_1234);
    busRead(3'd2, rd);  check("R2 count write ignored", rd, 32'h0);
    busWrite(3'd3, 32'hFFFF_FFFF);
    busRead(3'd3, rd);  check("R2 word 3 reads zero", rd, 32'h0);
    busWrite(3'd4, FALL | INTEN | AUTO);
    busRead(3'd4, rd);  check("R2 ctrl readback ch1", rd, FALL | INTEN | AUTO);
    busRead(3'd0, rd);  check("R2 ch0 ctrl untouched", rd, 32'h0);
    busWrite(3'd4, 32'h0);

    // R5 load bit holds counter at load value
    busWrite(3'd1, 32'd77);
    tickEn = 1'b1;
    busWrite(3'd0, LOADB | RUN);
    repeat (3) begin
      @(negedge clk);
      busRead(3'd2, rd);
      check("R5 count held at load", rd, 32'd77);
      check("R5 no event", {31'b0, evtOut[0]}, 32'h0);
    end
    busWrite(3'd0, 32'h0);
    tickEn = 1'b0;

    // R3 R4 R7 R9 generate mode, random ticks, both directions
    for (int it = 0; it < 6; it++) begin
      ch = it % 2;
      dn = (it < 3);
      l = dn ? 32'($urandom_range(6, 1)) : 32'hFFFF_FFFF - 32'($urandom_range(6, 1));
      mode = (dn ? DOWN : 32'h0) | AUTO | RUN | INTEN;
      busWrite(3'(ch * 4 + 1), l);
      busWrite(3'(ch * 4), LOADB);
      busWrite(3'(ch * 4), mode);
      busRead(3'(ch * 4 + 2), rd);
      check("R5 count loaded before run", rd, l);
      tk = 0;
      for (int cyc = 0; cyc < 40; cyc++) begin
        tkE = ($urandom % 4) != 0;
        tickEn = tkE;
        @(negedge clk);
        if (tkE) tk++;
        busRead(3'(ch * 4 + 2), rd);
        check(dn ? "R4 down count value" : "R4 up count value", rd, expCnt(l, dn, tk));
        check("R3 event pulse", {31'b0, evtOut[ch]},
              {31'b0, tkE && tk > 0 && (tk % periodOf(l, dn)) == 0});
      end
      tickEn = 1'b0;
      busRead(3'(ch * 4), rd);
      check("R3 flag after expiry", {31'b0, rd[8]}, {31'b0, tk >= periodOf(l, dn)});
      check("R9 irq follows flag", {31'b0, irq[ch]}, {31'b0, rd[8]});
      busWrite(3'(ch * 4), mode);
      busRead(3'(ch * 4), rd);
      check("R7 zero write keeps flag", {31'b0, rd[8]}, {31'b0, tk >= periodOf(l, dn)});
      busWrite(3'(ch * 4), mode | FLAGW);
      busRead(3'(ch * 4), rd);
      check("R7 one write clears flag", {31'b0, rd[8]}, 32'h0);
      check("R9 irq low after clear", {31'b0, irq[ch]}, 32'h0);
      busWrite(3'(ch * 4), 32'h0);
    end

    // R3 no auto-reload wraps; R9 irq masked
    busWrite(3'd1, 32'd2);
    busWrite(3'd0, LOADB);
    busWrite(3'd0, DOWN | RUN);
    tickEn = 1'b1;
    repeat (3) @(negedge clk);
    tickEn = 1'b0;
    busRead(3'd2, rd);  check("R3 wrap without reload", rd, 32'hFFFF_FFFF);
    busRead(3'd0, rd);  check("R3 flag on wrap", {31'b0, rd[8]}, 32'h1);
    check("R9 irq masked", {31'b0, irq[0]}, 32'h0);
    busWrite(3'd0, FLAGW);

    // R6 capture on channel 1
    busWrite(3'd5, 32'h0);
    busWrite(3'd4, LOADB);
    tickEn = 1'b1;
    busWrite(3'd4, CAP | RUN | INTEN);
    repeat (5) @(negedge clk);
    busRead(3'd6, c);
    capIn[1] = 1'b1;
    @(negedge clk);
    busRead(3'd5, rd);  check("R6 rising capture value", rd, c);
    busRead(3'd4, rd);  check("R6 capture sets flag", {31'b0, rd[8]}, 32'h1);
    check("R9 irq on capture", {31'b0, irq[1]}, 32'h1);
    busWrite(3'd4, CAP | RUN | FALL | FLAGW);
    repeat (3) @(negedge clk);
    busRead(3'd6, c);
    capIn[1] = 1'b0;
    @(negedge clk);
    busRead(3'd5, rd);  check("R6 falling capture value", rd, c);
    busWrite(3'd4, CAP | RUN | FALL | FLAGW);
    busRead(3'd5, l);
    capIn[1] = 1'b1;
    repeat (2) @(negedge clk);
    busRead(3'd5, rd);  check("R6 rising edge ignored in falling mode", rd, l);
    busRead(3'd4, rd);  check("R6 no flag on ignored edge", {31'b0, rd[8]}, 32'h0);
    busWrite(3'd4, FLAGW);
    tickEn = 1'b0;
    capIn = '0;

    // R8 PWM
    for (int it = 0; it < 3; it++) begin
      lp = $urandom_range(8, 3);
      lh = $urandom_range(lp - 1, 0);
      busWrite(3'd1, 32'(lp));
      busWrite(3'd0, LOADB);
      busWrite(3'd0, DOWN | AUTO | PWM | RUN);
      busWrite(3'd5, 32'(lh));
      busWrite(3'd4, LOADB);
      busWrite(3'd4, DOWN | PWM | RUN);
      check("R8 pwm low before start", {31'b0, pwmOut}, 32'h0);
      tickEn = 1'b1;
      for (int t = 1; t <= 30; t++) begin
        @(negedge clk);
        check("R8 pwm waveform", {31'b0, pwmOut}, {31'b0, expPwm(lp, lh, t)});
      end
      busWrite(3'd4, DOWN | RUN);
      @(negedge clk);
      check("R8 pwm low when disabled", {31'b0, pwmOut}, 32'h0);
      tickEn = 1'b0;
      busWrite(3'd0, FLAGW);
      busWrite(3'd4, FLAGW);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule